// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a down-counter paired with a second register of the same width. The second register holds the reload value in the counting modes and receives the captured count in the capture modes. A three-bit mode field picks the behaviour, and a separate run bit gates all activity. In the timer modes the counter steps once per cycle in which the instruction-rate enable `tick_en` is high. In the event modes it steps on a chosen edge of the external pin instead. In the capture modes it runs freely, and a chosen pin edge records the live count.

Each time the counter reloads in a reload mode, and each time a capture edge arrives in a capture mode, a sticky pending flag is set. An enable bit decides whether that flag drives `irq`. In one timer mode every reload also inverts a dedicated output pin, which produces square waves, or PWM when software changes the reload value between periods. Software reaches every register a byte at a time through a small byte-wide port. The width of the counter is a parameter, and by default it is 16 bits.

Top module: `tmr16_multi`

## Requirements
- R1: After reset the counter, the reload/capture register, the control register and the interrupt register all read 0, and `pin_out` and `irq` are 0.
- R2: Register port map for the default width. Offset 0 is the counter low byte and offset 1 the counter high byte. Offset 2 is the reload/capture low byte and offset 3 the reload/capture high byte. Offset 4 is control: bits 7:5 are the mode and bit 4 is run, and bits 3:0 read as 0. Offset 5 is interrupt: bit 0 is the enable and bit 1 is pending. Offsets 6 and 7 read as 0. Reads are combinational and writes take effect at the next clock edge.
- R3: Modes 100 and 101 with run set: the counter decrements by one at each clock edge where `tick_en` is 1. When it is 0 it loads the reload value instead and sets pending. A reload value r therefore gives a period of r+1 ticks, from 1 up to 65536.
- R4: In mode 101 each reload inverts `pin_out`. In every other mode `pin_out` holds its level.
- R5: Modes 000 and 001 count rising or falling edges, respectively, of `pin_in`, independent of `tick_en`, with the same reload and pending behaviour as R3. A pin change that lands before clock edge k shows on the counter after edge k+2.
- R6: Modes 110 and 111 with run set: the counter decrements on `tick_en` and wraps from 0 to all ones without setting pending. A rising edge (110) or a falling edge (111) of `pin_in`, seen after edge k+1 as in R5, copies the count that is current at edge k+2 into the reload/capture register and sets pending. The opposite edge does nothing.
- R7: With run cleared, the counter, the reload/capture register, pending and `pin_out` do not change except by software writes.
- R8: Mode codes 010 and 011 hold the counter and the reload/capture register frozen and set no pending, even with run set.
- R9: Pending stays set until software writes 1 to interrupt bit 1. If a hardware set and that clear fall in the same cycle, the set wins. `irq` is pending AND enable.
- R10: A software write to a counter byte replaces that byte of the current count, and the counter skips its step in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Instruction-rate count enable |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte, combinational |
| pin_in | input | 1 | Asynchronous event or capture input |
| pin_out | output | 1 | Toggle output |
| irq | output | 1 | Interrupt request |

## Verification
Register writes and tick-driven steps are due one edge after the stimulus. Pin-driven counts and captures are due on the third edge after the pin changes, because the path runs through two synchronizer flops and an edge register. The bench drives and samples on falling edges and opens `tick_en` for an exact number of rising edges, so the expected count, pending state and output parity can be computed arithmetically from the period formula. Edge latency is checked directly: the counter is sampled after the first, second and third edges that follow a pin change. The same-cycle collisions (write against step, clear against set) are driven in a single shared cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [2:0] {
      MODE_EVT_RISE = 3'b000,
      MODE_EVT_FALL = 3'b001,
      MODE_BAD_A    = 3'b010,
      MODE_BAD_B    = 3'b011,
      MODE_TMR      = 3'b100,
      MODE_TMR_TGL  = 3'b101,
      MODE_CAP_RISE = 3'b110,
      MODE_CAP_FALL = 3'b111
   } tmr_mode_e;

   function automatic logic mode_is_event(input tmr_mode_e m);
      return (m == MODE_EVT_RISE) || (m == MODE_EVT_FALL);
   endfunction

   function automatic logic mode_is_capture(input tmr_mode_e m);
      return (m == MODE_CAP_RISE) || (m == MODE_CAP_FALL);
   endfunction

   function automatic logic mode_is_legal(input tmr_mode_e m);
      return (m != MODE_BAD_A) && (m != MODE_BAD_B);
   endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic rise_o,
   output logic fall_o
);
   localparam int TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("tmr_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
         prev_q <= sync_q[TOP];
      end
   end

   assign rise_o = sync_q[TOP] & ~prev_q;
   assign fall_o = ~sync_q[TOP] & prev_q;

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
   parameter int WIDTH = 16,
   localparam int NB   = WIDTH / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_ok,
   input  logic             step,
   input  logic             reload_en,
   input  logic             cap_stb,
   input  logic [NB-1:0]    cnt_wmask,
   input  logic [NB-1:0]    rld_wmask,
   input  logic [7:0]       wbyte,
   output logic [WIDTH-1:0] cnt_o,
   output logic [WIDTH-1:0] rld_o,
   output logic             uflow_o,
   output logic             cap_o
);
   logic [WIDTH-1:0] cnt_q, cnt_d;
   logic [WIDTH-1:0] rld_q, rld_d;
   logic             cnt_hit_zero;

   assign cnt_hit_zero = (cnt_q == '0);

   always_comb begin
      cnt_d = cnt_q;
      if (run_ok && step) begin
         if (cnt_hit_zero) cnt_d = reload_en ? rld_q : '1;
         else              cnt_d = cnt_q - WIDTH'(1);
      end
      if (|cnt_wmask) begin
         cnt_d = cnt_q;
         for (int b = 0; b < NB; b++)
            if (cnt_wmask[b]) cnt_d[b*8 +: 8] = wbyte;
      end
   end

   always_comb begin
      rld_d = rld_q;
      if (run_ok && cap_stb) rld_d = cnt_q;
      if (|rld_wmask) begin
         rld_d = rld_q;
         for (int b = 0; b < NB; b++)
            if (rld_wmask[b]) rld_d[b*8 +: 8] = wbyte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rld_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         rld_q <= rld_d;
      end
   end

   assign uflow_o = run_ok && step && reload_en && cnt_hit_zero && !(|cnt_wmask);
   assign cap_o   = run_ok && cap_stb;
   assign cnt_o   = cnt_q;
   assign rld_o   = rld_q;

endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_i,
   input  logic en_d_i,
   input  logic clr_d_i,
   output logic pend_o,
   output logic en_o,
   output logic irq_o
);
   logic pend_q, en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         if (wr_i) en_q <= en_d_i;
         if (set_i)                pend_q <= 1'b1;
         else if (wr_i && clr_d_i) pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;
   assign en_o   = en_q;
   assign irq_o  = pend_q & en_q;

endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
   import tmr_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int NB         = WIDTH / 8,
   localparam int NREG       = 2 * NB + 2,
   localparam int AW         = $clog2(NREG),
   localparam int CTRL_IDX   = 2 * NB,
   localparam int IRQ_IDX    = 2 * NB + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_wr,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    reg_rdata,
   input  logic          pin_in,
   output logic          pin_out,
   output logic          irq
);
   if ((WIDTH % 8) != 0 || WIDTH < 8) begin : g_bad_width
      $error("tmr16_multi: WIDTH must be a positive multiple of 8");
   end

   tmr_mode_e        mode_q;
   logic             run_q;
   logic             pin_q;
   logic             rise, fall;
   logic             cnt_step, cap_stb, reload_en, run_ok;
   logic [NB-1:0]    cnt_wmask, rld_wmask;
   logic [WIDTH-1:0] cnt_val, rld_val;
   logic             uflow, cap_evt;
   logic             ctrl_wr, irq_wr, clr_wr;
   logic             pend, irq_en;

   // byte-lane write decode
   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign cnt_wmask[g] = reg_wr && (reg_addr == AW'(g));
      assign rld_wmask[g] = reg_wr && (reg_addr == AW'(NB + g));
   end

   assign ctrl_wr = reg_wr && (reg_addr == AW'(CTRL_IDX));
   assign irq_wr  = reg_wr && (reg_addr == AW'(IRQ_IDX));
   assign clr_wr  = irq_wr && reg_wdata[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_EVT_RISE;
         run_q  <= 1'b0;
      end else if (ctrl_wr) begin
         mode_q <= tmr_mode_e'(reg_wdata[7:5]);
         run_q  <= reg_wdata[4];
      end
   end

   tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_async(pin_in),
      .rise_o   (rise),
      .fall_o   (fall)
   );

   // mode decode: step source, capture strobe, reload vs wrap
   always_comb begin
      cnt_step = tick_en;
      cap_stb  = 1'b0;
      unique case (mode_q)
         MODE_EVT_RISE: cnt_step = rise;
         MODE_EVT_FALL: cnt_step = fall;
         MODE_CAP_RISE: cap_stb  = rise;
         MODE_CAP_FALL: cap_stb  = fall;
         default:       ;
      endcase
   end

   assign reload_en = !mode_is_capture(mode_q);
   assign run_ok    = run_q && mode_is_legal(mode_q);

   tmr_count_unit #(.WIDTH(WIDTH)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_ok   (run_ok),
      .step     (cnt_step),
      .reload_en(reload_en),
      .cap_stb  (cap_stb),
      .cnt_wmask(cnt_wmask),
      .rld_wmask(rld_wmask),
      .wbyte    (reg_wdata),
      .cnt_o    (cnt_val),
      .rld_o    (rld_val),
      .uflow_o  (uflow),
      .cap_o    (cap_evt)
   );

   tmr_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (uflow | cap_evt),
      .wr_i   (irq_wr),
      .en_d_i (reg_wdata[0]),
      .clr_d_i(reg_wdata[1]),
      .pend_o (pend),
      .en_o   (irq_en),
      .irq_o  (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             pin_q <= 1'b0;
      else if (uflow && mode_q == MODE_TMR_TGL) pin_q <= ~pin_q;
   end
   assign pin_out = pin_q;

   always_comb begin
      reg_rdata = 8'h00;
      for (int b = 0; b < NB; b++) begin
         if (reg_addr == AW'(b))      reg_rdata = cnt_val[b*8 +: 8];
         if (reg_addr == AW'(NB + b)) reg_rdata = rld_val[b*8 +: 8];
      end
      if (reg_addr == AW'(CTRL_IDX)) reg_rdata = {mode_q, run_q, 4'b0000};
      if (reg_addr == AW'(IRQ_IDX))  reg_rdata = {6'b000000, pend, irq_en};
   end

endmodule

// File: rtl/tmr16_multi_chk.sv
module tmr16_multi_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       mode,
   input logic             run,
   input logic             step,
   input logic             cap_stb,
   input logic             cnt_wr,
   input logic             rld_wr,
   input logic [WIDTH-1:0] cnt,
   input logic [WIDTH-1:0] rld,
   input logic             pin_out,
   input logic             pend,
   input logic             clr_wr
);
   logic reload_mode, capture_mode, legal;
   assign reload_mode  = (mode == 3'b000) || (mode == 3'b001) ||
                         (mode == 3'b100) || (mode == 3'b101);
   assign capture_mode = (mode == 3'b110) || (mode == 3'b111);
   assign legal        = mode[2] || !mode[1];

   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && reload_mode && step && cnt == '0 && !cnt_wr) |=> cnt == $past(rld));

   assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && legal && step && cnt != '0 && !cnt_wr) |=> cnt == $past(cnt) - WIDTH'(1));

   assert_pin_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 3'b101) |=> $stable(pin_out));

   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && capture_mode && step && cnt == '0 && !cnt_wr) |=> cnt == '1);

   assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && capture_mode && cap_stb && !rld_wr) |=> rld == $past(cnt));

   assert_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt));

   assert_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!legal && !cnt_wr && !rld_wr) |=> ($stable(cnt) && $stable(rld)));

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr_wr) |=> pend);

endmodule

bind tmr16_multi tmr16_multi_chk #(.WIDTH(WIDTH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mode   (mode_q),
   .run    (run_q),
   .step   (cnt_step),
   .cap_stb(cap_stb),
   .cnt_wr (|cnt_wmask),
   .rld_wr (|rld_wmask),
   .cnt    (cnt_val),
   .rld    (rld_val),
   .pin_out(pin_out),
   .pend   (pend),
   .clr_wr (clr_wr)
);

// File: tb/tb_tmr16_multi.sv
`timescale 1ns/1ps
module tb_tmr16_multi;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       pin_in = 1'b0;
   logic       pin_out;
   logic       irq;

   int checks = 0;
   int errors = 0;
   logic exp_pin = 1'b0;

   always #4 clk = ~clk;

   tmr16_multi dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd_cnt(output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(3'd0, lo); rd(3'd1, hi);
      v = {hi, lo};
   endtask

   task automatic rd_rld(output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(3'd2, lo); rd(3'd3, hi);
      v = {hi, lo};
   endtask

   task automatic rd_pend(output logic p);
      logic [7:0] d;
      rd(3'd5, d);
      p = d[1];
   endtask

   task automatic setup(input logic [15:0] c0, input logic [15:0] r,
                        input logic [2:0] mode, input logic run);
      wr(3'd4, 8'h00);
      wr(3'd0, c0[7:0]); wr(3'd1, c0[15:8]);
      wr(3'd2, r[7:0]);  wr(3'd3, r[15:8]);
      wr(3'd5, 8'h02);
      wr(3'd4, {mode, run, 4'b0000});
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      if (n > 0) begin
         tick_en = 1'b1;
         repeat (n) @(negedge clk);
         tick_en = 1'b0;
      end
   endtask

   task automatic pulse();
      @(negedge clk); pin_in = 1'b1;
      repeat (4) @(negedge clk);
      pin_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   function automatic int exp_cnt(int c0, int r, int n);
      if (n <= c0) return c0 - n;
      return r - ((n - c0 - 1) % (r + 1));
   endfunction

   function automatic int exp_uf(int c0, int r, int n);
      if (n <= c0) return 0;
      return 1 + (n - c0 - 1) / (r + 1);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      logic [7:0]  d;
      logic        p;
      int          rl[4] = '{0, 1, 2, 5};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d);
         chk($sformatf("R1 reg %0d", a), d, 8'h00);
      end
      chk("R1 pin_out", pin_out, 1'b0);
      chk("R1 irq", irq, 1'b0);

      // R2 register map and read back
      wr(3'd2, 8'h5A); wr(3'd3, 8'hC3);
      rd_rld(v); chk("R2 reload bytes", v, 16'hC35A);
      wr(3'd4, 8'h8F); rd(3'd4, d); chk("R2 ctrl low bits", d, 8'h80);
      wr(3'd4, 8'h00);
      rd(3'd6, d); chk("R2 offset 6", d, 8'h00);
      rd(3'd7, d); chk("R2 offset 7", d, 8'h00);

      // R3/R4 timer sweep
      foreach (rl[i]) begin
         for (int c = 0; c < 2; c++) begin
            for (int n = 0; n < 8; n++) begin
               int c0;
               logic [2:0] m;
               c0 = (c == 0) ? 0 : 3;
               m  = (c == 0) ? 3'b100 : 3'b101;
               setup(16'(c0), 16'(rl[i]), m, 1'b1);
               ticks(n);
               rd_cnt(v);
               chk($sformatf("R3 cnt r=%0d c0=%0d n=%0d", rl[i], c0, n), v, 32'(exp_cnt(c0, rl[i], n)));
               rd_pend(p);
               chk($sformatf("R3 pend r=%0d c0=%0d n=%0d", rl[i], c0, n), p, exp_uf(c0, rl[i], n) > 0);
               if (m == 3'b101) exp_pin = exp_pin ^ exp_uf(c0, rl[i], n) [0];
               chk($sformatf("R4 pin r=%0d c0=%0d n=%0d", rl[i], c0, n), pin_out, exp_pin);
            end
         end
      end
      chk("R9 irq masked", irq, 1'b0);

      // R3 full-range reload
      setup(16'h0000, 16'hFFFF, 3'b100, 1'b1);
      ticks(1); rd_cnt(v); chk("R3 max reload", v, 16'hFFFF);
      ticks(1); rd_cnt(v); chk("R3 max reload step", v, 16'hFFFE);

      // R5 event counting, tick_en high to show independence
      setup(16'd2, 16'd4, 3'b000, 1'b1);
      tick_en = 1'b1;
      for (int k = 1; k <= 7; k++) begin
         pulse();
         rd_cnt(v); chk($sformatf("R5 rise k=%0d", k), v, 32'(exp_cnt(2, 4, k)));
      end
      tick_en = 1'b0;
      setup(16'd2, 16'd4, 3'b001, 1'b1);
      for (int k = 1; k <= 4; k++) begin
         pulse();
         rd_cnt(v); chk($sformatf("R5 fall k=%0d", k), v, 32'(exp_cnt(2, 4, k)));
      end
      rd_pend(p); chk("R5 pend fall", p, 1'b1);
      @(negedge clk); pin_in = 1'b1;
      repeat (6) @(negedge clk);
      rd_cnt(v); chk("R5 fall ignores rise", v, 32'(exp_cnt(2, 4, 4)));
      @(negedge clk); pin_in = 1'b0;
      repeat (6) @(negedge clk);

      // R5 latency: third edge after pin change
      setup(16'd10, 16'd0, 3'b000, 1'b1);
      @(negedge clk); reg_addr = 3'd0; pin_in = 1'b1;
      @(negedge clk); chk("R5 latency edge1", reg_rdata, 8'd10);
      @(negedge clk); chk("R5 latency edge2", reg_rdata, 8'd10);
      @(negedge clk); chk("R5 latency edge3", reg_rdata, 8'd9);
      pin_in = 1'b0;
      repeat (6) @(negedge clk);

      // R6 capture
      setup(16'h1234, 16'h0000, 3'b110, 1'b1);
      pulse();
      rd_rld(v); chk("R6 capture rise", v, 16'h1234);
      rd_pend(p); chk("R6 capture pend", p, 1'b1);
      setup(16'h0ABC, 16'h0000, 3'b111, 1'b1);
      @(negedge clk); pin_in = 1'b1;
      repeat (6) @(negedge clk);
      rd_rld(v); chk("R6 fall mode ignores rise", v, 16'h0000);
      rd_pend(p); chk("R6 no pend on rise", p, 1'b0);
      @(negedge clk); pin_in = 1'b0;
      repeat (6) @(negedge clk);
      rd_rld(v); chk("R6 capture fall", v, 16'h0ABC);
      setup(16'h0100, 16'h0000, 3'b110, 1'b1);
      @(negedge clk); tick_en = 1'b1; pin_in = 1'b1;
      repeat (5) @(negedge clk);
      tick_en = 1'b0; pin_in = 1'b0;
      repeat (6) @(negedge clk);
      rd_rld(v); chk("R6 capture while running", v, 16'h00FE);
      rd_cnt(v); chk("R6 count while running", v, 16'h00FB);
      setup(16'h0001, 16'h5555, 3'b110, 1'b1);
      ticks(3);
      rd_cnt(v); chk("R6 wrap", v, 16'hFFFE);
      rd_pend(p); chk("R6 wrap no pend", p, 1'b0);
      rd_rld(v); chk("R6 wrap keeps reload", v, 16'h5555);

      // R7 stopped
      setup(16'd7, 16'd3, 3'b101, 1'b0);
      ticks(10);
      rd_cnt(v); chk("R7 stopped cnt", v, 16'd7);
      rd_pend(p); chk("R7 stopped pend", p, 1'b0);
      chk("R7 stopped pin", pin_out, exp_pin);

      // R8 illegal codes
      for (int m = 2; m < 4; m++) begin
         setup(16'd7, 16'd3, 3'(m), 1'b1);
         ticks(10);
         pulse();
         rd_cnt(v); chk($sformatf("R8 mode %0d cnt", m), v, 16'd7);
         rd_rld(v); chk($sformatf("R8 mode %0d rld", m), v, 16'd3);
         rd_pend(p); chk($sformatf("R8 mode %0d pend", m), p, 1'b0);
      end

      // R9 set wins over clear, irq gating
      setup(16'd0, 16'd5, 3'b100, 1'b1);
      wr(3'd5, 8'h01);
      @(negedge clk);
      tick_en = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h03; reg_wr = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; reg_wr = 1'b0;
      rd_pend(p); chk("R9 set wins", p, 1'b1);
      chk("R9 irq asserted", irq, 1'b1);
      wr(3'd5, 8'h03);
      rd_pend(p); chk("R9 cleared", p, 1'b0);
      chk("R9 irq dropped", irq, 1'b0);

      // R10 write beats step
      setup(16'h0105, 16'h0000, 3'b100, 1'b1);
      @(negedge clk);
      tick_en = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h20; reg_wr = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; reg_wr = 1'b0;
      rd_cnt(v); chk("R10 write wins", v, 16'h0120);
      ticks(1);
      rd_cnt(v); chk("R10 resumes", v, 16'h011F);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule